// File: doc/BRIEF.md
# Partial Timestamp Seconds Reconstructor

This block turns a compact hardware timestamp into a full time value. The compact form keeps only the two lowest bits of the seconds count, together with the full nanoseconds field. A reference time is sampled from the running clock at least once per second. The block rebuilds the missing upper seconds bits from that reference and picks the candidate that lies closest to it.

The first candidate takes the reference seconds, replaces their two low bits with the fragment, and compares the result with the reference at nanosecond resolution. The seconds part of that difference, taken after any borrow from the nanoseconds, decides the wrap. When it is above +2 the candidate is moved back by four seconds. When it is below -2 the candidate is moved forward by four seconds. Nanoseconds pass through untouched. The result is registered, so a valid input gives a valid output one cycle later.

Top module: `ts_seconds_recon`

## Requirements
- R1: During and after reset, before the first valid input, `outValid` is 0 and `outSec` and `outNsec` are 0.
- R2: `outValid` equals `inValid` delayed by exactly one clock cycle.
- R3: One cycle after a valid input, `outNsec` equals the `inNsec` of that input, unchanged.
- R4: One cycle after a valid input, `outSec[1:0]` equals `inSecLo` of that input.
- R5: Let cand = {refSec[31:2], inSecLo} and d = inSecLo - refSec[1:0] - b, where b = 1 if inNsec < refNsec, else 0. When d is between -2 and +2 inclusive, `outSec` is cand.
- R6: When d is +3, `outSec` is cand - 4.
- R7: When d is -3 or -4, `outSec` is cand + 4.
- R8: The nanosecond borrow b changes the decision. For example, refSec[1:0]=0 and inSecLo=3 give cand-4 when inNsec >= refNsec, but cand when inNsec < refNsec.
- R9: The seconds arithmetic wraps modulo 2^32. refSec=0 with inSecLo=3 and no borrow gives 0xFFFFFFFF. refSec=0xFFFFFFFF with inSecLo=0 and no borrow gives 0.
- R10: In a cycle where `inValid` is 0, `outSec` and `outNsec` keep their values in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Partial timestamp present this cycle |
| inSecLo | input | 2 | Low seconds bits of the partial timestamp |
| inNsec | input | 30 | Nanoseconds of the partial timestamp |
| refSec | input | 32 | Reference seconds sampled from the clock |
| refNsec | input | 30 | Reference nanoseconds sampled from the clock |
| outValid | output | 1 | Reconstructed time valid |
| outSec | output | 32 | Reconstructed full seconds |
| outNsec | output | 30 | Nanoseconds passed through |

## Verification
A wrong wrap decision shows as an `outSec` that is off by exactly four seconds from the expected value. It appears in the cycle right after the input. A missing or inverted nanosecond borrow flips the decision only at the edge cases d=+3 and d=-2, or d=+2 and d=-3. For that reason the directed cases place the two nanosecond fields on either side of each other at those edges. A corrupted valid pipeline or capture strobe shows within one cycle as a wrong `outValid`, or as outputs that change while no input is valid.

// File: rtl/ts_recon_pkg.sv
package ts_recon_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;
  } reconStrobes_t;
endpackage

// File: rtl/ts_recon_ctrl.sv
module ts_recon_ctrl
  import ts_recon_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output reconStrobes_t strobes,
  output logic          validQ
);
  always_comb strobes.load = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> validQ);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !validQ);
endmodule

// File: rtl/ts_recon_data.sv
module ts_recon_data
  import ts_recon_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int FRAG_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  reconStrobes_t     strobes,
  input  logic [FRAG_W-1:0] fragIn,
  input  logic [NS_W-1:0]   nsIn,
  input  logic [SEC_W-1:0]  refSec,
  input  logic [NS_W-1:0]   refNs,
  output logic [SEC_W-1:0]  secQ,
  output logic [NS_W-1:0]   nsQ
);
  localparam int SPAN = 1 << FRAG_W;
  localparam int HALF = SPAN / 2;
  localparam int DW   = FRAG_W + 2;
  localparam logic signed [DW-1:0]  HALF_POS = DW'(HALF);
  localparam logic signed [DW-1:0]  HALF_NEG = -DW'(HALF);
  localparam logic [SEC_W-1:0]      SPAN_V   = SEC_W'(SPAN);
  localparam logic [SEC_W-1:0]      REACH    = SEC_W'(HALF + 1);
  localparam logic [SEC_W-1:0]      REACH2   = SEC_W'(2 * HALF + 2);

  logic                    nsBorrow;
  logic signed [DW-1:0]    secDiff;
  logic [SEC_W-1:0]        candSec;
  logic [SEC_W-1:0]        pickSec;

  always_comb begin
    nsBorrow = (nsIn < refNs);
    secDiff  = $signed({2'b00, fragIn})
             - $signed({2'b00, refSec[FRAG_W-1:0]})
             - $signed({{(DW-1){1'b0}}, nsBorrow});
    candSec  = {refSec[SEC_W-1:FRAG_W], fragIn};
    if (secDiff > HALF_POS)      pickSec = candSec - SPAN_V;
    else if (secDiff < HALF_NEG) pickSec = candSec + SPAN_V;
    else                         pickSec = candSec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ <= '0;
      nsQ  <= '0;
    end else if (strobes.load) begin
      secQ <= pickSec;
      nsQ  <= nsIn;
    end
  end

  // R3
  ns_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> nsQ == $past(nsIn));
  // R4
  frag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> secQ[FRAG_W-1:0] == $past(fragIn));
  // R5
  near_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (secQ - $past(refSec) + REACH) <= REACH2);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(secQ) && $stable(nsQ));
endmodule

// File: rtl/ts_seconds_recon.sv
module ts_seconds_recon
  import ts_recon_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int FRAG_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [FRAG_W-1:0] inSecLo,
  input  logic [NS_W-1:0]   inNsec,
  input  logic [SEC_W-1:0]  refSec,
  input  logic [NS_W-1:0]   refNsec,
  output logic              outValid,
  output logic [SEC_W-1:0]  outSec,
  output logic [NS_W-1:0]   outNsec
);
  reconStrobes_t strobes;

  ts_recon_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .validQ  (outValid)
  );

  ts_recon_data #(.SEC_W(SEC_W), .NS_W(NS_W), .FRAG_W(FRAG_W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .fragIn  (inSecLo),
    .nsIn    (inNsec),
    .refSec  (refSec),
    .refNs   (refNsec),
    .secQ    (outSec),
    .nsQ     (outNsec)
  );

  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rstN |=> !outValid && outSec == '0 && outNsec == '0);
endmodule

// File: tb/tb_ts_seconds_recon.sv
module tb_ts_seconds_recon;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inSecLo = '0;
  logic [29:0] inNsec = '0;
  logic [31:0] refSec = '0;
  logic [29:0] refNsec = '0;
  logic        outValid;
  logic [31:0] outSec;
  logic [29:0] outNsec;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  ts_seconds_recon dut (.*);

  function automatic logic [31:0] model(input logic [31:0] rs, input logic [29:0] rn,
                                        input logic [1:0] fr, input logic [29:0] ns);
    logic [31:0] cand;
    int d;
    cand = {rs[31:2], fr};
    d = int'(fr) - int'(rs[1:0]) - ((ns < rn) ? 1 : 0);
    if (d > 2)       return cand - 32'd4;
    else if (d < -2) return cand + 32'd4;
    return cand;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [31:0] rs, input logic [29:0] rn,
                       input logic [1:0] fr, input logic [29:0] ns);
    logic [31:0] e;
    e = model(rs, rn, fr, ns);
    @(negedge clk);
    inValid = 1'b1; refSec = rs; refNsec = rn; inSecLo = fr; inNsec = ns;
    @(negedge clk);
    inValid = 1'b0;
    chk({req, " sec"}, 64'(outSec), 64'(e));
    chk("R2 valid", 64'(outValid), 64'd1);
    chk("R3 nsec", 64'(outNsec), 64'(ns));
    chk("R4 low bits", 64'(outSec[1:0]), 64'(fr));
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] holdSec;
    logic [29:0] holdNs;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 valid", 64'(outValid), 64'd0);
    chk("R1 sec", 64'(outSec), 64'd0);
    chk("R1 nsec", 64'(outNsec), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after", 64'(outSec), 64'd0);

    apply("R5", 32'd5, 30'd100, 2'd3, 30'd50);          // d=1 -> 7
    apply("R5", 32'd100, 30'd0, 2'd2, 30'd10);          // d=2
    apply("R6", 32'd100, 30'd10, 2'd3, 30'd20);         // d=3 -> 99
    apply("R7", 32'd103, 30'd10, 2'd0, 30'd20);         // d=-3 -> 104
    apply("R7", 32'd103, 30'd20, 2'd0, 30'd10);         // d=-4 -> 104
    apply("R8", 32'd100, 30'd500, 2'd3, 30'd400);       // borrow, d=2 -> 103
    apply("R8", 32'd103, 30'd500, 2'd1, 30'd400);       // borrow, d=-3 -> 105
    apply("R9", 32'd0, 30'd0, 2'd3, 30'd7);             // 0xFFFFFFFF
    apply("R9", 32'hFFFF_FFFF, 30'd9, 2'd0, 30'd9);     // 0
    chk("R9 direct", 64'(outSec), 64'd0);

    // R10: idle cycle keeps outputs even with changed inputs
    holdSec = outSec; holdNs = outNsec;
    @(negedge clk);
    refSec = 32'h1234_5678; inSecLo = 2'd1; inNsec = 30'd77;
    @(negedge clk);
    chk("R10 sec", 64'(outSec), 64'(holdSec));
    chk("R10 nsec", 64'(outNsec), 64'(holdNs));
    chk("R2 idle", 64'(outValid), 64'd0);

    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rs;
      logic [29:0] rn, ns;
      rs = $urandom;
      if (i % 4 == 0) rs = 32'hFFFF_FFF0 + 32'($urandom % 32);
      rn = 30'($urandom % 1_000_000_000);
      ns = 30'($urandom % 1_000_000_000);
      apply("R5-R7 random", rs, rn, 2'($urandom), ns);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule